// File: doc/BRIEF.md
# Strobed Input Port Interrupt Controller

This block provides two 8-bit general-purpose ports behind a small register bus. Each port is an input or an output. In input mode the port holds a data latch. The latch clock is the port's strobe pin XORed with a software polarity bit. While that effective clock is low, the latch follows the pins. When it rises, the latch freezes and the port's interrupt flag is set.

Flipping the polarity bit while the strobe is held steady has the same effect as a strobe edge. This gives a software-triggered capture and a software interrupt, even when the strobe pin is tied high or low. Strobe and data pins pass through two-flop synchronizers, and all edge detection runs on the system clock.

A shared active-low interrupt request is asserted while any flag is set together with its enable. The open-drain pad is represented by a drive-low enable. Flags are cleared in one of two ways, chosen by a configuration bit. In one mode, software writes a zero to the flag bit. In the other mode, reading the port's data register clears its flag.

Top module: `strobe_port_irq`

## Requirements
- R1: After reset, the configuration register (address 0) reads 0 and the status register (address 1) reads 0, so both ports are inputs with polarity 0, all flags and enables are clear, and `irq_n` is 1.
- R2: While a port's synchronized strobe equals its polarity bit, its data register (address 2 for port A, 3 for port B) returns the current pin values within 4 clock cycles of a pin change.
- R3: A rising edge of (strobe XOR polarity) on an input port freezes the data register at the pin values present before the edge. It also sets the port's flag (status bit 0 for port A, bit 1 for port B). Pin changes while the clock stays high are not captured.
- R4: Writing the polarity bit (configuration bit 2 for A, bit 3 for B) from 0 to 1 while the strobe is low captures and sets the flag. Writing it back to 0 sets no flag.
- R5: A port configured as output (configuration bit 0 for A, bit 1 for B) never sets its flag. Its output enable is high, and its pins carry the last value written to its data register, which also reads back.
- R6: `irq_n` is 0 exactly when some flag is set and its enable is set (status bit 4 for A, bit 5 for B). This includes an enable written after the flag is pending. `irq_pull` is always the inverse of `irq_n`.
- R7: With the clear-mode bit (configuration bit 4) set, writing 0 to a flag bit of the status register clears that flag. Writing 1 has no effect, and reading the data register leaves the flag unchanged.
- R8: With the clear-mode bit clear, reading a port's data register clears that port's flag only, and status writes do not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 config, 1 status/enable, 2 port A data, 3 port B data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for clear-on-read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A pins, input side |
| pb_in | input | 8 | Port B pins, input side |
| pa_stb | input | 1 | Port A strobe pin |
| pb_stb | input | 1 | Port B strobe pin |
| pa_out | output | 8 | Port A output value |
| pb_out | output | 8 | Port B output value |
| pa_oe | output | 1 | Port A output enable |
| pb_oe | output | 1 | Port B output enable |
| irq_n | output | 1 | Active-low interrupt request |
| irq_pull | output | 1 | Drive-low enable for the open-drain request pad |

## Verification
Capture is driven in two ways. Strobe pin toggles and polarity bit writes are interleaved at random, so an error in the XOR or in edge polarity shows up as a missed or extra flag. Pin values change both while the effective clock is low and while it is high. This separates a transparent latch from a frozen one, and a capture of pre-edge data from one that takes post-edge data. Random switching of direction, enables and clear mode, followed by data reads and status writes with random bit patterns, tells the two clearing paths apart. It also shows whether a write of 1 or an output port can set a flag.

// File: rtl/strobe_port_irq.sv
module strobe_port_irq #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic         pa_stb,
  input  logic         pb_stb,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pb_out,
  output logic         pa_oe,
  output logic         pb_oe,
  output logic         irq_n,
  output logic         irq_pull
);
  localparam int NP = 2;

  logic [NP-1:0]   dir, pol, en, flag, eff, eff_q, rise, stb_s;
  logic            wz;
  logic [W-1:0]    pin  [NP];
  logic [W-1:0]    dat_s[NP];
  logic [W-1:0]    latch[NP];
  logic [W-1:0]    outr [NP];
  logic [SYNC-1:0] ssh  [NP];
  logic [W-1:0]    dsh  [NP][SYNC];

  assign pin[0] = pa_in;
  assign pin[1] = pb_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        ssh[p] <= '0;
        for (int k = 0; k < SYNC; k++) dsh[p][k] <= '0;
      end
    end else begin
      ssh[0] <= {ssh[0][SYNC-2:0], pa_stb};
      ssh[1] <= {ssh[1][SYNC-2:0], pb_stb};
      for (int p = 0; p < NP; p++) begin
        dsh[p][0] <= pin[p];
        for (int k = 1; k < SYNC; k++) dsh[p][k] <= dsh[p][k-1];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      stb_s[p] = ssh[p][SYNC-1];
      dat_s[p] = dsh[p][SYNC-1];
    end
  end

  assign eff  = stb_s ^ pol;
  assign rise = eff & ~eff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= '0;
      for (int p = 0; p < NP; p++) latch[p] <= '0;
    end else begin
      eff_q <= eff;
      for (int p = 0; p < NP; p++)
        if (!eff[p]) latch[p] <= dat_s[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0;
      pol <= '0;
      wz  <= 1'b0;
      en  <= '0;
      for (int p = 0; p < NP; p++) outr[p] <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          dir <= reg_wdata[1:0];
          pol <= reg_wdata[3:2];
          wz  <= reg_wdata[4];
        end
        2'd1:    en      <= reg_wdata[5:4];
        2'd2:    outr[0] <= reg_wdata;
        default: outr[1] <= reg_wdata;
      endcase
    end
  end

  logic [NP-1:0] clr;
  always_comb begin
    for (int p = 0; p < NP; p++)
      clr[p] = ( wz && reg_wr && reg_addr == 2'd1 && !reg_wdata[p])
            || (!wz && reg_rd && reg_addr == 2'(2 + p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= (rise & ~dir) | (flag & ~clr);
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[4:0] = {wz, pol, dir};
      2'd1:    begin reg_rdata[5:4] = en; reg_rdata[1:0] = flag; end
      2'd2:    reg_rdata = dir[0] ? outr[0] : latch[0];
      default: reg_rdata = dir[1] ? outr[1] : latch[1];
    endcase
  end

  assign pa_out   = outr[0];
  assign pb_out   = outr[1];
  assign pa_oe    = dir[0];
  assign pb_oe    = dir[1];
  assign irq_pull = |(flag & en);
  assign irq_n    = ~irq_pull;
endmodule

module strobe_port_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   eff,
  input logic [1:0]   eff_q,
  input logic [1:0]   flag,
  input logic [1:0]   dir,
  input logic [1:0]   en,
  input logic         wz,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [1:0]   reg_addr,
  input logic         irq_n,
  input logic [W-1:0] lat_a,
  input logic [W-1:0] lat_b
);
  assert_flag_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> $past(eff[0] && !eff_q[0]));
  assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eff[0] |=> $stable(lat_a));
  assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eff[1] |=> $stable(lat_b));
  assert_out_noflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir[1] && !flag[1]) |=> !flag[1]);
  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && en[1]) |-> !irq_n);
  assert_no_write_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && !flag[0] && !(eff[0] && !eff_q[0])) |=> !flag[0]);
  assert_wz_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wz && reg_rd && !reg_wr && reg_addr == 2'd2 && flag[0]) |=> flag[0]);
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wz && reg_rd && reg_addr == 2'd3 && !(eff[1] && !eff_q[1])) |=> !flag[1]);
endmodule

bind strobe_port_irq strobe_port_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eff(eff), .eff_q(eff_q), .flag(flag), .dir(dir),
  .en(en), .wz(wz), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .irq_n(irq_n), .lat_a(latch[0]), .lat_b(latch[1])
);

// File: tb/test_strobe_port_irq.sv
`timescale 1ns/1ps
module test_strobe_port_irq;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [7:0] pa_out, pb_out;
  logic pa_oe, pb_oe, irq_n, irq_pull;

  logic [7:0] pin_m [2];
  logic [1:0] stb_m, flag_m, en_m;
  logic [7:0] cfg_m, latch_m [2], out_m [2];
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobe_port_irq i_strobe_port_irq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pa_in(pin_m[0]), .pb_in(pin_m[1]),
    .pa_stb(stb_m[0]), .pb_stb(stb_m[1]), .pa_out(pa_out), .pb_out(pb_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .irq_n(irq_n), .irq_pull(irq_pull));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic eff_m(input int p);
    return stb_m[p] ^ cfg_m[2+p];
  endfunction

  function automatic logic [7:0] exp_status();
    return {2'b00, en_m, 2'b00, flag_m};
  endfunction

  function automatic logic [7:0] exp_data(input int p);
    return cfg_m[p] ? out_m[p] : latch_m[p];
  endfunction

  task automatic after_clock(input int p, input logic prev);
    logic now;
    settle(5);
    now = eff_m(p);
    if (!prev && now && !cfg_m[p]) flag_m[p] = 1;
    if (!now) latch_m[p] = pin_m[p];
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(2'd1, d);
    check({tag, " status"}, d, exp_status());
    check({tag, " irq_n R6"}, irq_n, !(|(flag_m & en_m)));
    check({tag, " irq_pull R6"}, irq_pull, |(flag_m & en_m));
    check({tag, " pins R5"}, {pa_oe, pb_oe, pa_out, pb_out},
          {cfg_m[0], cfg_m[1], out_m[0], out_m[1]});
  endtask

  task automatic set_pin(input int p, input logic [7:0] v);
    @(negedge clk); pin_m[p] = v; settle(5);
    if (!eff_m(p)) latch_m[p] = v;
  endtask

  task automatic toggle_stb(input int p);
    logic prev = eff_m(p);
    @(negedge clk); stb_m[p] = ~stb_m[p];
    after_clock(p, prev);
  endtask

  task automatic write_cfg(input logic [7:0] c);
    logic [1:0] prev;
    prev[0] = eff_m(0); prev[1] = eff_m(1);
    cfg_m = c & 8'h1f;
    wr(2'd0, c);
    settle(4);
    for (int p = 0; p < 2; p++) begin
      if (!prev[p] && eff_m(p) && !cfg_m[p]) flag_m[p] = 1;
      if (!eff_m(p)) latch_m[p] = pin_m[p];
    end
  endtask

  task automatic write_status(input logic [7:0] d);
    wr(2'd1, d);
    en_m = d[5:4];
    if (cfg_m[4]) flag_m = flag_m & d[1:0];
  endtask

  task automatic read_data(input int p, input string tag);
    logic [7:0] d;
    rd(2'(2 + p), d);
    check(tag, d, exp_data(p));
    if (!cfg_m[4]) flag_m[p] = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    pin_m[0] = 0; pin_m[1] = 0; stb_m = 0; flag_m = 0; en_m = 0; cfg_m = 0;
    latch_m[0] = 0; latch_m[1] = 0; out_m[0] = 0; out_m[1] = 0;
    settle(3); rst_n = 1; settle(3);

    rd(2'd0, d); check("R1 config", d, 8'h00);
    rd(2'd1, d); check("R1 status", d, 8'h00);
    check("R1 irq_n", irq_n, 1'b1);

    set_pin(0, 8'hA5); read_data(0, "R2 transparent A");
    set_pin(1, 8'h3C); read_data(1, "R2 transparent B");

    toggle_stb(0);
    check("R3 flag set", flag_m[0], 1'b1);
    set_pin(0, 8'h11); read_data(0, "R3 frozen after edge");
    check_all("R8 read cleared");
    toggle_stb(0); check_all("R3 falling no flag");

    write_status(8'h10);
    write_cfg(8'h04);
    check_all("R4 polarity capture");
    write_cfg(8'h00); check_all("R4 polarity back no flag");
    write_status(8'h10);
    check_all("R7 mode0 status write ignored");

    write_cfg(8'h12); write_status(8'h30);
    toggle_stb(1); check_all("R5 output port no flag");
    wr(2'd3, 8'h9E); out_m[1] = 8'h9E; read_data(1, "R5 output readback");
    check_all("R5 output pins");

    write_status(8'h00); toggle_stb(0);
    check_all("R6 disabled flag no irq");
    write_status(8'h13); check_all("R6 late enable asserts");
    read_data(0, "R7 read keeps flag"); check_all("R7 read keeps flag");
    write_status(8'h12); check_all("R7 write zero clears");

    for (int i = 0; i < 400; i++) begin
      int p = int'($urandom % 2);
      case ($urandom % 8)
        0: begin set_pin(p, 8'($urandom)); check_all("R2 rnd pins"); end
        1, 2: begin toggle_stb(p); check_all("R3 rnd strobe"); end
        3: begin write_cfg(cfg_m ^ (8'h04 << p)); check_all("R4 rnd polarity"); end
        4: begin write_status(8'($urandom)); check_all("R7 rnd status write"); end
        5: begin read_data(p, "R8 rnd data read"); check_all("R8 rnd after read"); end
        6: begin
             if ($urandom % 4 == 0) write_cfg(cfg_m ^ (8'h01 << p));
             else write_cfg(cfg_m ^ 8'h10);
             check_all("R5 rnd cfg");
           end
        default: begin
             d = 8'($urandom); wr(2'(2 + p), d); out_m[p] = d;
             check_all("R5 rnd out write");
           end
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule